// File: doc/BRIEF.md
# Downstream Port Reset Chirp Sequencer

This block runs the reset of a single downstream-facing port. Once a reset request is accepted it drives SE0 on the port for a fixed number of clock cycles. During that window it watches the filtered line state for a device chirp K. If a long enough chirp K appears, the block answers after a short gap with its own alternating chirp K / chirp J sequence. That sequence is timed so it is over a set margin before the reset window closes. At the end of the window the port is enabled and its speed is reported. The speed is high when the handshake took place. Otherwise it is low or full, taken from the idle line state seen when the request was accepted.

All timing is given in clock cycles through parameters. An integrator derives them from the clock rate and the signalling limits:

| Parameter | Meaning | Limit to respect |
|-----------|---------|------------------|
| RST_CYC | length of the reset window | 10 to 20 ms |
| FILT_CYC | filter length for the device chirp K | at least 2.5 µs |
| GAP_CYC | gap before the first hub chirp | total reaction under 100 µs |
| CHIRP_CYC | length of each hub chirp | 40 to 60 µs |
| MARGIN_CYC | quiet time left before the window closes | 100 to 500 µs |

A disconnect seen during the window abandons the sequence and leaves the port disabled. The transceiver, squelch and packet traffic are outside this block.

Top module: `port_reset_chirp_seq`

## Requirements
- R1: A request is accepted at a clock edge. In the RST_CYC cycles that follow, the port drives exactly one of SE0 or a chirp in every cycle. The done pulse comes in the cycle right after those RST_CYC cycles.
- R2: Counting starts only after the request has been accepted. A device chirp K is recognised only when line_k is sampled high on FILT_CYC consecutive edges. A shorter run of line_k has no effect on the speed result and starts no hub chirp.
- R3: After recognition, take the first cycle in which line_k is low. The first hub chirp K is driven GAP_CYC+1 cycles after that cycle.
- R4: Hub chirps alternate K then J, starting with K. Each lasts exactly CHIRP_CYC cycles, with no SE0 cycle between them. drive_se0 is low while a chirp is driven.
- R5: Count reset cycles from 0, the first cycle after acceptance. A hub chirp may start at cycle s only if s+CHIRP_CYC <= RST_CYC-MARGIN_CYC. If it does not start, SE0 is driven until the window closes.
- R6: If no device chirp K was recognised, speed ends as 2'b00 (low) when line_k was high at acceptance. Otherwise it ends as 2'b01 (full).
- R7: done is high for one cycle only. In that cycle port_en becomes 1, and port_en and speed then hold until the next accepted request. After reset, port_en is 0 and speed is 2'b11 (none).
- R8: Suppose disconnect is high at an edge during the reset window. In the next cycle every drive output is low, port_en is 0 and speed is 2'b11, and no done pulse follows.
- R9: A request is accepted only while idle, with disconnect low and with line_j or line_k high. Requests at any other time have no effect.
- R10: At most one of drive_se0, drive_chirp_k and drive_chirp_j is high in any cycle. None of them is high while idle.
- R11: If a device chirp K was recognised, speed ends as 2'b10 (high). This holds even when no hub chirp fitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reset_req | input | 1 | request to reset the port |
| line_j | input | 1 | filtered line state J |
| line_k | input | 1 | filtered line state K |
| disconnect | input | 1 | disconnect seen on the port |
| drive_se0 | output | 1 | drive SE0 on the port |
| drive_chirp_k | output | 1 | drive a chirp K |
| drive_chirp_j | output | 1 | drive a chirp J |
| done | output | 1 | one-cycle end-of-reset pulse |
| port_en | output | 1 | port enabled after a completed reset |
| speed | output | 2 | 00 low, 01 full, 10 high, 11 none |

## Verification
A wrong state in this block shows up at the drive pins within a cycle. A missed recognition leaves SE0 where a chirp K was due GAP_CYC+1 cycles after the device released the line. A phase slip turns a K into a J or a J into a K on the same edge. A timer that is off by one moves the done pulse and the port_en rise by that same cycle. A stuck state after a disconnect keeps a drive pin high in the very next cycle. A cycle-accurate model therefore exposes each fault within at most one chirp length of its cause.

// File: rtl/prc_pkg.sv
package prc_pkg;

  typedef enum logic [1:0] {
    SPD_LOW  = 2'b00,
    SPD_FULL = 2'b01,
    SPD_HIGH = 2'b10,
    SPD_NONE = 2'b11
  } speed_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LISTEN,
    ST_DEVK,
    ST_GAP,
    ST_CHIRP,
    ST_TAIL
  } seq_state_e;

  // A chirp that starts in the next cycle (now_t + 1) must end by stop_t.
  function automatic logic chirp_fits(input int unsigned now_t,
                                      input int unsigned len,
                                      input int unsigned stop_t);
    return (now_t + 32'd1 + len) <= stop_t;
  endfunction

endpackage

// File: rtl/prc_span_cnt.sv
module prc_span_cnt #(
  parameter int unsigned LIMIT = 4,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (en && (cnt != TOP))  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/port_reset_chirp_seq.sv
module port_reset_chirp_seq
  import prc_pkg::*;
#(
  parameter int unsigned RST_CYC    = 400,
  parameter int unsigned FILT_CYC   = 4,
  parameter int unsigned GAP_CYC    = 3,
  parameter int unsigned CHIRP_CYC  = 10,
  parameter int unsigned MARGIN_CYC = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reset_req,
  input  logic       line_j,
  input  logic       line_k,
  input  logic       disconnect,
  output logic       drive_se0,
  output logic       drive_chirp_k,
  output logic       drive_chirp_j,
  output logic       done,
  output logic       port_en,
  output logic [1:0] speed
);

  localparam int unsigned STOP_T = RST_CYC - MARGIN_CYC;
  localparam int unsigned TW = $clog2(RST_CYC + 1);
  localparam int unsigned KW = $clog2(FILT_CYC + 1);
  localparam int unsigned GW = $clog2(GAP_CYC + 1);
  localparam int unsigned CW = $clog2(CHIRP_CYC + 1);

  seq_state_e state_q;
  logic       ph_q;      // 0: chirp K, 1: chirp J
  logic       hs_q;
  speed_e     hint_q;
  speed_e     speed_q;
  logic       en_q;
  logic       done_q;

  // named internal events
  logic          busy;
  logic          start_ev;
  logic          abort_ev;
  logic          rst_end_ev;
  logic          dev_k_seen;
  logic          t_last;
  logic          k_last;
  logic          gap_last;
  logic          chirp_last;
  logic          fits_now;
  logic [TW-1:0] rst_tick;
  logic [KW-1:0] k_cnt;
  logic [GW-1:0] gap_cnt;
  logic [CW-1:0] chirp_cnt;

  assign busy       = (state_q != ST_IDLE);
  assign start_ev   = !busy && reset_req && !disconnect && (line_j || line_k);
  assign abort_ev   = busy && disconnect;
  assign t_last     = (rst_tick == TW'(RST_CYC - 1));
  assign rst_end_ev = busy && !disconnect && t_last;
  assign k_last     = (k_cnt == KW'(FILT_CYC - 1));
  assign dev_k_seen = (state_q == ST_LISTEN) && line_k && k_last;
  assign gap_last   = (gap_cnt == GW'(GAP_CYC - 1));
  assign chirp_last = (chirp_cnt == CW'(CHIRP_CYC - 1));
  assign fits_now   = chirp_fits({{(32-TW){1'b0}}, rst_tick}, CHIRP_CYC, STOP_T);

  prc_span_cnt #(.LIMIT(RST_CYC)) u_rst_timer (
    .clk(clk), .rst_n(rst_n), .clr(!busy), .en(busy), .cnt(rst_tick)
  );

  prc_span_cnt #(.LIMIT(FILT_CYC)) u_kfilt (
    .clk(clk), .rst_n(rst_n),
    .clr(!((state_q == ST_LISTEN) && line_k)), .en(1'b1), .cnt(k_cnt)
  );

  prc_span_cnt #(.LIMIT(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .clr(state_q != ST_GAP), .en(1'b1), .cnt(gap_cnt)
  );

  prc_span_cnt #(.LIMIT(CHIRP_CYC)) u_chirp (
    .clk(clk), .rst_n(rst_n), .clr((state_q != ST_CHIRP) || chirp_last),
    .en(1'b1), .cnt(chirp_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
      hs_q    <= 1'b0;
      hint_q  <= SPD_FULL;
      speed_q <= SPD_NONE;
      en_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_ev) begin
        state_q <= ST_IDLE;
        en_q    <= 1'b0;
        speed_q <= SPD_NONE;
      end else if (rst_end_ev) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
        en_q    <= 1'b1;
        speed_q <= hs_q ? SPD_HIGH : hint_q;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_ev) begin
            state_q <= ST_LISTEN;
            hs_q    <= 1'b0;
            en_q    <= 1'b0;
            speed_q <= SPD_NONE;
            hint_q  <= line_k ? SPD_LOW : SPD_FULL;
          end
          ST_LISTEN: if (dev_k_seen) begin
            hs_q    <= 1'b1;
            state_q <= ST_DEVK;
          end
          ST_DEVK: if (!line_k) state_q <= ST_GAP;
          ST_GAP: if (gap_last) begin
            ph_q    <= 1'b0;
            state_q <= fits_now ? ST_CHIRP : ST_TAIL;
          end
          ST_CHIRP: if (chirp_last) begin
            if (fits_now) ph_q <= ~ph_q;
            else          state_q <= ST_TAIL;
          end
          default: ;
        endcase
      end
    end
  end

  assign drive_chirp_k = (state_q == ST_CHIRP) && !ph_q;
  assign drive_chirp_j = (state_q == ST_CHIRP) && ph_q;
  assign drive_se0     = busy && (state_q != ST_CHIRP);
  assign done          = done_q;
  assign port_en       = en_q;
  assign speed         = speed_q;

endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
  parameter int unsigned RST_CYC    = 400,
  parameter int unsigned MARGIN_CYC = 20,
  parameter int unsigned TW         = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          start_ev,
  input logic          disconnect,
  input logic          drive_se0,
  input logic          drive_chirp_k,
  input logic          drive_chirp_j,
  input logic          done,
  input logic          port_en,
  input logic [1:0]    speed,
  input logic [TW-1:0] rst_tick
);

  logic [31:0] busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 32'd1;
    else           busy_run <= '0;
  end

  // R1
  rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < RST_CYC));

  // R1
  busy_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (drive_se0 || drive_chirp_k || drive_chirp_j));

  // R5
  chirp_margin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_chirp_k || drive_chirp_j) |-> (rst_tick < TW'(RST_CYC - MARGIN_CYC)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (port_en && (speed != 2'b11)));

  // R7
  speed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_ev) |=> ($stable(speed) && $stable(port_en)));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && disconnect) |=> (!busy && !port_en && !done && (speed == 2'b11)));

  // R10
  drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drive_se0, drive_chirp_k, drive_chirp_j}));

endmodule

bind port_reset_chirp_seq prc_checker #(
  .RST_CYC(RST_CYC), .MARGIN_CYC(MARGIN_CYC), .TW(TW)
) u_prc_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start_ev(start_ev),
  .disconnect(disconnect), .drive_se0(drive_se0),
  .drive_chirp_k(drive_chirp_k), .drive_chirp_j(drive_chirp_j),
  .done(done), .port_en(port_en), .speed(speed), .rst_tick(rst_tick)
);

// File: tb/tb_port_reset_chirp_seq.sv
`timescale 1ns/1ps
module tb_port_reset_chirp_seq;

  localparam int RST    = 400;
  localparam int FILT   = 4;
  localparam int GAP    = 3;
  localparam int CHIRP  = 10;
  localparam int MARGIN = 20;
  localparam int STOP   = RST - MARGIN;

  logic clk = 1'b0;
  logic rst_n, reset_req, line_j, line_k, disconnect;
  logic drive_se0, drive_chirp_k, drive_chirp_j, done, port_en;
  logic [1:0] speed;

  always #5 clk = ~clk;

  port_reset_chirp_seq #(
    .RST_CYC(RST), .FILT_CYC(FILT), .GAP_CYC(GAP),
    .CHIRP_CYC(CHIRP), .MARGIN_CYC(MARGIN)
  ) dut (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .line_j(line_j),
    .line_k(line_k), .disconnect(disconnect), .drive_se0(drive_se0),
    .drive_chirp_k(drive_chirp_k), .drive_chirp_j(drive_chirp_j),
    .done(done), .port_en(port_en), .speed(speed)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // ---------------- behavioural reference model ----------------
  int m_act = 0, m_el = 0, m_krun = 0, m_ph = 0, m_sub = 0, m_idx = 0;
  int m_hs = 0, m_hint = 1, m_en = 0, m_spd = 3, m_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_en = 0; m_spd = 3; m_done = 0; m_hs = 0; m_hint = 1; m_ph = 0;
    end else begin
      m_done = 0;
      if (m_act == 0) begin
        if (reset_req && !disconnect && (line_j || line_k)) begin
          m_act = 1; m_el = 0; m_krun = 0; m_ph = 0; m_hs = 0;
          m_en = 0; m_spd = 3; m_hint = line_k ? 0 : 1;
        end
      end else if (disconnect) begin
        m_act = 0; m_en = 0; m_spd = 3;
      end else if (m_el == RST - 1) begin
        m_act = 0; m_done = 1; m_en = 1; m_spd = m_hs ? 2 : m_hint;
      end else begin
        m_el++;
        case (m_ph)
          0: if (line_k) begin
               m_krun++;
               if (m_krun == FILT) begin m_hs = 1; m_ph = 1; end
             end else m_krun = 0;
          1: if (!line_k) begin m_ph = 2; m_sub = 0; end
          2: begin
               m_sub++;
               if (m_sub == GAP) begin
                 if (m_el + CHIRP <= STOP) begin m_ph = 3; m_sub = 0; m_idx = 0; end
                 else m_ph = 4;
               end
             end
          3: begin
               m_sub++;
               if (m_sub == CHIRP) begin
                 if (m_el + CHIRP <= STOP) begin m_idx++; m_sub = 0; end
                 else m_ph = 4;
               end
             end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk_eq("R1 drive_se0", int'(drive_se0), (m_act == 1 && m_ph != 3) ? 1 : 0);
      chk_eq("R4 drive_chirp_k", int'(drive_chirp_k), (m_act == 1 && m_ph == 3 && m_idx % 2 == 0) ? 1 : 0);
      chk_eq("R4 drive_chirp_j", int'(drive_chirp_j), (m_act == 1 && m_ph == 3 && m_idx % 2 == 1) ? 1 : 0);
      chk_eq("R7 done", int'(done), m_done);
      chk_eq("R7 port_en", int'(port_en), m_en);
      chk_eq("R6_R11 speed", int'(speed), m_spd);
    end
  end

  // ---------------- directed stimulus and measurement ----------------
  int w_se0, w_k, w_j, w_firstk, w_firstj, w_lastch, w_done;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_reset();
    reset_req = 1'b1;
    @(negedge clk);
    reset_req = 1'b0;
  endtask

  task automatic watch();
    w_se0 = 0; w_k = 0; w_j = 0; w_firstk = -1; w_firstj = -1; w_lastch = -1; w_done = -1;
    for (int i = 0; i < RST + 50; i++) begin
      if (done) begin w_done = i; break; end
      if (drive_se0) w_se0++;
      if (drive_chirp_k) begin
        w_k++; w_lastch = i;
        if (w_firstk < 0) w_firstk = i;
      end
      if (drive_chirp_j) begin
        w_j++; w_lastch = i;
        if (w_firstj < 0) w_firstj = i;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; reset_req = 1'b0; line_j = 1'b0; line_k = 1'b0; disconnect = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // reset state
    chk_eq("R7 reset port_en", int'(port_en), 0);
    chk_eq("R7 reset speed", int'(speed), 3);
    chk_eq("R10 reset drive_se0", int'(drive_se0), 0);
    chk_eq("R10 reset chirp", int'(drive_chirp_k | drive_chirp_j), 0);

    // full-speed device, plus a stray request in the middle (R9)
    line_j = 1'b1;
    fork
      begin start_reset(); watch(); end
      begin step(50); reset_req = 1'b1; step(1); reset_req = 1'b0; end
    join
    chk_eq("R1 fs done index", w_done, RST);
    chk_eq("R1 fs se0 cycles", w_se0, RST);
    chk_eq("R9 fs no chirp", w_k + w_j, 0);
    chk_eq("R6 fs speed", int'(speed), 1);
    chk_eq("R7 fs port_en", int'(port_en), 1);
    step(1);
    chk_eq("R7 done one cycle", int'(done), 0);
    step(20);
    chk_eq("R7 speed held", int'(speed), 1);
    chk_eq("R7 port_en held", int'(port_en), 1);

    // low-speed device
    line_j = 1'b0; line_k = 1'b1;
    fork
      begin start_reset(); watch(); end
      begin step(1); line_k = 1'b0; end
    join
    chk_eq("R6 ls speed", int'(speed), 0);
    chk_eq("R1 ls done index", w_done, RST);
    step(5);

    // high-speed handshake
    line_j = 1'b1;
    fork
      begin start_reset(); watch(); end
      begin step(20); line_j = 1'b0; line_k = 1'b1; step(30); line_k = 1'b0; end
    join
    begin
      int s0 = 49 + GAP + 1;
      int n = (STOP - s0) / CHIRP;
      chk_eq("R11 hs speed", int'(speed), 2);
      chk_eq("R3 first hub chirp K", w_firstk, s0);
      chk_eq("R4 first chirp J", w_firstj, s0 + CHIRP);
      chk_eq("R4 K cycles", w_k, ((n + 1) / 2) * CHIRP);
      chk_eq("R4 J cycles", w_j, (n / 2) * CHIRP);
      chk_eq("R5 last chirp cycle", w_lastch, s0 + n * CHIRP - 1);
      chk_eq("R5 margin kept", (RST - 1 - w_lastch >= MARGIN) ? 1 : 0, 1);
      chk_eq("R1 hs total drive", w_se0 + w_k + w_j, RST);
    end
    step(5);

    // short K run below the filter length
    line_j = 1'b1;
    fork
      begin start_reset(); watch(); end
      begin step(20); line_j = 1'b0; line_k = 1'b1; step(FILT - 1); line_k = 1'b0; end
    join
    chk_eq("R2 short K speed", int'(speed), 1);
    chk_eq("R2 short K no chirp", w_k + w_j, 0);
    step(5);

    // K run of exactly the filter length
    line_j = 1'b1;
    fork
      begin start_reset(); watch(); end
      begin step(20); line_j = 1'b0; line_k = 1'b1; step(FILT); line_k = 1'b0; end
    join
    chk_eq("R2 exact K speed", int'(speed), 2);
    chk_eq("R3 exact K first chirp", w_firstk, 20 + FILT - 1 + GAP + 1);
    step(5);

    // late device chirp: no hub chirp fits
    line_j = 1'b1;
    fork
      begin start_reset(); watch(); end
      begin step(370); line_j = 1'b0; line_k = 1'b1; step(6); line_k = 1'b0; end
    join
    chk_eq("R5 late no chirp", w_k + w_j, 0);
    chk_eq("R11 late speed", int'(speed), 2);
    chk_eq("R1 late done index", w_done, RST);
    step(5);

    // disconnect during reset
    line_j = 1'b1;
    start_reset();
    step(99);
    disconnect = 1'b1;
    step(1);
    disconnect = 1'b0;
    chk_eq("R8 abort drive_se0", int'(drive_se0), 0);
    chk_eq("R8 abort port_en", int'(port_en), 0);
    chk_eq("R8 abort speed", int'(speed), 3);
    step(RST + 20);
    chk_eq("R8 no late enable", int'(port_en), 0);

    // request with no device on the line
    line_j = 1'b0; line_k = 1'b0;
    start_reset();
    step(2);
    chk_eq("R9 no device ignored", int'(drive_se0), 0);
    chk_eq("R9 no device speed", int'(speed), 3);
    step(5);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule